// File: doc/BRIEF.md
# Paged Window Memory Mapper

This block sits between a processor with a 20-bit address bus and two memory targets: a conventional memory that sees processor addresses unchanged, and a large expanded memory addressed in 16 KB pages. A 64 KB window at physical 0xE0000 to 0xEFFFF, above the 640 KB conventional region, is carved into four 16 KB slots. Each slot has its own page register, so software can point each slot at any of 256 expanded pages (4 MB in all) without disturbing the other three. An access inside the window is steered to expanded memory with an address built from the slot's page register. Any other access goes to conventional memory as it is.

Each page register holds an 8-bit page number and an enable bit. Software programs them through four consecutive I/O ports that start at `IO_BASE` (0x68 by default). Port `IO_BASE+k` writes slot k. A window access through a slot whose enable bit is clear is completed by the mapper itself: reads return 0xFF, and writes are discarded.

Processor requests use a valid/ready handshake that passes straight through to whichever target is selected. While `cpu_req_valid` is high and `cpu_req_ready` is low, the processor must hold the request fields steady. A transfer completes in the cycle where both are high. Read data for that cycle is presented combinationally on `cpu_rdata`.

Top module: `pager_window_map`

## Requirements
- R1: After reset every slot is disabled, so a window access completes at once with `cpu_rdata` = 0xFF and raises neither target's valid.
- R2: An I/O write (`io_wr_en` high) to port `IO_BASE+k`, k = 0..3, loads slot k with page number `io_wdata[7:0]` and enable `io_wdata[8]`. Writes to any other port change no slot.
- R3: For an address below 0xE0000 or at or above 0xF0000, `conv_req_valid` follows `cpu_req_valid`. Address, write enable and write data pass unchanged. `cpu_req_ready` follows `conv_req_ready` and `cpu_rdata` follows `conv_rdata`.
- R4: For a window address whose slot is enabled, `exp_req_valid` follows `cpu_req_valid`, and `exp_req_addr` = {page number of the slot, address bits 13:0}. `cpu_req_ready` follows `exp_req_ready` and `cpu_rdata` follows `exp_rdata`.
- R5: The slot is chosen by address bits 15:14 (0xE0000 to slot 0 through 0xEC000 to slot 3). Each slot translates with its own page register, independent of the others.
- R6: A window access through a disabled slot raises no target valid, completes with `cpu_req_ready` high, and reads 0xFF. A write made this way changes no memory.
- R7: At most one target valid is high in any cycle. The processor ready is the selected target's ready, so back-pressure from that target stalls the processor.
- R8: A page-register write takes effect in the cycle after `io_wr_en`. A window access in the same cycle as the write uses the old slot contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr_en | input | 1 | I/O port write strobe |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 9 | Bit 8 is the slot enable; bits 7:0 are the page number |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 20 | Processor physical address |
| cpu_req_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data for the accepted request |
| conv_req_valid | output | 1 | Conventional memory request valid |
| conv_req_ready | input | 1 | Conventional memory ready |
| conv_req_we | output | 1 | Conventional memory write enable |
| conv_req_addr | output | 20 | Conventional memory address |
| conv_req_wdata | output | 8 | Conventional memory write data |
| conv_rdata | input | 8 | Conventional memory read data |
| exp_req_valid | output | 1 | Expanded memory request valid |
| exp_req_ready | input | 1 | Expanded memory ready |
| exp_req_we | output | 1 | Expanded memory write enable |
| exp_req_addr | output | 22 | Expanded memory address |
| exp_req_wdata | output | 8 | Expanded memory write data |
| exp_rdata | input | 8 | Expanded memory read data |

## Verification
The hardest case to reach from the ports is a page-register write that lands in the same cycle as a window access through the same slot. The old mapping must be used in that cycle and the new one in the next. The stimulus sets up a slot, then rewrites it while accessing it, and repeats this with the slot being disabled. A second hard case is a stalled request while the selected target holds ready low. The bench keeps the request steady and drops each target's ready in turn. A long random phase then mixes I/O writes, including ports just outside the block's range, with accesses on both sides of the window edges.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int unsigned ADDR_W   = 20;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned OFF_W    = 14;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned PNUM_W   = 8;
  localparam int unsigned IO_AW    = 8;

  typedef enum logic [1:0] {
    ROUTE_CONV = 2'd0,
    ROUTE_EXP  = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;
endpackage

// File: rtl/pmap_page_regs.sv
module pmap_page_regs #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned PNUM_W  = 8,
  parameter int unsigned IO_AW   = 8,
  parameter logic [IO_AW-1:0] IO_BASE = 8'h68,
  localparam int unsigned NSLOT  = 1 << SEL_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          io_wr_en,
  input  logic [IO_AW-1:0]              io_addr,
  input  logic [PNUM_W:0]               io_wdata,
  output logic [NSLOT-1:0][PNUM_W-1:0]  page_num,
  output logic [NSLOT-1:0]              page_en
);
  logic port_hit;
  logic [SEL_W-1:0] wr_slot;

  assign port_hit = io_wr_en && (io_addr[IO_AW-1:SEL_W] == IO_BASE[IO_AW-1:SEL_W]);
  assign wr_slot  = io_addr[SEL_W-1:0];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic sel;
    assign sel = port_hit && (wr_slot == SEL_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        page_en[k]  <= 1'b0;
        page_num[k] <= '0;
      end else if (sel) begin
        page_en[k]  <= io_wdata[PNUM_W];
        page_num[k] <= io_wdata[PNUM_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pmap_window_decode.sv
module pmap_window_decode #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned OFF_W  = 14,
  parameter int unsigned SEL_W  = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hE0000,
  localparam int unsigned HI_W  = ADDR_W - OFF_W
) (
  input  logic [HI_W-1:0]  addr_hi,
  output logic             win_hit,
  output logic [SEL_W-1:0] slot
);
  assign win_hit = (addr_hi[HI_W-1:SEL_W] == WIN_BASE[ADDR_W-1:OFF_W+SEL_W]);
  assign slot    = addr_hi[SEL_W-1:0];
endmodule

// File: rtl/pmap_addr_form.sv
module pmap_addr_form #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned PNUM_W = 8,
  parameter int unsigned OFF_W  = 14,
  localparam int unsigned NSLOT = 1 << SEL_W,
  localparam int unsigned EXP_W = PNUM_W + OFF_W
) (
  input  logic [NSLOT-1:0][PNUM_W-1:0] page_num,
  input  logic [NSLOT-1:0]             page_en,
  input  logic [SEL_W-1:0]             slot,
  input  logic [OFF_W-1:0]             offset,
  output logic [EXP_W-1:0]             exp_addr,
  output logic                         slot_en
);
  assign exp_addr = {page_num[slot], offset};
  assign slot_en  = page_en[slot];
endmodule

// File: rtl/pager_window_map.sv
module pager_window_map
  import pmap_pkg::*;
#(
  parameter int unsigned A_W     = ADDR_W,
  parameter int unsigned D_W     = DATA_W,
  parameter int unsigned O_W     = OFF_W,
  parameter int unsigned S_W     = SEL_W,
  parameter int unsigned P_W     = PNUM_W,
  parameter int unsigned IOA_W   = IO_AW,
  parameter logic [A_W-1:0]   WIN_BASE = 20'hE0000,
  parameter logic [IOA_W-1:0] IO_BASE  = 8'h68,
  localparam int unsigned NSLOT  = 1 << S_W,
  localparam int unsigned EXP_W  = P_W + O_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr_en,
  input  logic [IOA_W-1:0] io_addr,
  input  logic [P_W:0]     io_wdata,
  input  logic             cpu_req_valid,
  output logic             cpu_req_ready,
  input  logic             cpu_req_we,
  input  logic [A_W-1:0]   cpu_req_addr,
  input  logic [D_W-1:0]   cpu_req_wdata,
  output logic [D_W-1:0]   cpu_rdata,
  output logic             conv_req_valid,
  input  logic             conv_req_ready,
  output logic             conv_req_we,
  output logic [A_W-1:0]   conv_req_addr,
  output logic [D_W-1:0]   conv_req_wdata,
  input  logic [D_W-1:0]   conv_rdata,
  output logic             exp_req_valid,
  input  logic             exp_req_ready,
  output logic             exp_req_we,
  output logic [EXP_W-1:0] exp_req_addr,
  output logic [D_W-1:0]   exp_req_wdata,
  input  logic [D_W-1:0]   exp_rdata
);
  logic [NSLOT-1:0][P_W-1:0] page_num;
  logic [NSLOT-1:0]          page_en;
  logic                      win_hit;
  logic [S_W-1:0]            slot;
  logic                      slot_en;
  route_e                    route;

  pmap_page_regs #(
    .SEL_W(S_W), .PNUM_W(P_W), .IO_AW(IOA_W), .IO_BASE(IO_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .io_wr_en(io_wr_en), .io_addr(io_addr),
    .io_wdata(io_wdata), .page_num(page_num), .page_en(page_en)
  );

  pmap_window_decode #(
    .ADDR_W(A_W), .OFF_W(O_W), .SEL_W(S_W), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr_hi(cpu_req_addr[A_W-1:O_W]), .win_hit(win_hit), .slot(slot)
  );

  pmap_addr_form #(
    .SEL_W(S_W), .PNUM_W(P_W), .OFF_W(O_W)
  ) u_form (
    .page_num(page_num), .page_en(page_en), .slot(slot),
    .offset(cpu_req_addr[O_W-1:0]), .exp_addr(exp_req_addr), .slot_en(slot_en)
  );

  always_comb begin
    if (!win_hit)     route = ROUTE_CONV;
    else if (slot_en) route = ROUTE_EXP;
    else              route = ROUTE_DROP;
  end

  assign conv_req_valid = cpu_req_valid && (route == ROUTE_CONV);
  assign exp_req_valid  = cpu_req_valid && (route == ROUTE_EXP);
  assign conv_req_addr  = cpu_req_addr;
  assign conv_req_we    = cpu_req_we;
  assign conv_req_wdata = cpu_req_wdata;
  assign exp_req_we     = cpu_req_we;
  assign exp_req_wdata  = cpu_req_wdata;

  always_comb begin
    unique case (route)
      ROUTE_CONV: begin cpu_req_ready = conv_req_ready; cpu_rdata = conv_rdata; end
      ROUTE_EXP:  begin cpu_req_ready = exp_req_ready;  cpu_rdata = exp_rdata;  end
      default:    begin cpu_req_ready = 1'b1;           cpu_rdata = '1;         end
    endcase
  end
endmodule

// File: rtl/pmap_checker.sv
module pmap_checker #(
  parameter int unsigned A_W   = 20,
  parameter int unsigned D_W   = 8,
  parameter int unsigned O_W   = 14,
  parameter int unsigned S_W   = 2,
  parameter int unsigned P_W   = 8,
  parameter int unsigned IOA_W = 8,
  parameter logic [A_W-1:0]   WIN_BASE = 20'hE0000,
  parameter logic [IOA_W-1:0] IO_BASE  = 8'h68,
  localparam int unsigned EXP_W = P_W + O_W
) (
  input logic             clk,
  input logic             rst,
  input logic             io_wr_en,
  input logic [IOA_W-1:0] io_addr,
  input logic [P_W:0]     io_wdata,
  input logic             cpu_req_valid,
  input logic             cpu_req_ready,
  input logic [A_W-1:0]   cpu_req_addr,
  input logic [D_W-1:0]   cpu_rdata,
  input logic             conv_req_valid,
  input logic             conv_req_ready,
  input logic [A_W-1:0]   conv_req_addr,
  input logic             exp_req_valid,
  input logic             exp_req_ready,
  input logic [EXP_W-1:0] exp_req_addr
);
  logic in_win;
  logic io_slot_wr;
  assign in_win = (cpu_req_addr[A_W-1:O_W+S_W] == WIN_BASE[A_W-1:O_W+S_W]);
  assign io_slot_wr = io_wr_en && io_wdata[P_W] &&
                      (io_addr[IOA_W-1:S_W] == IO_BASE[IOA_W-1:S_W]);

  p_passthru_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && !in_win) |->
      (conv_req_valid && !exp_req_valid && conv_req_addr == cpu_req_addr));

  p_offset_r4: assert property (@(posedge clk) disable iff (rst)
    exp_req_valid |-> (in_win && cpu_req_valid &&
      exp_req_addr[O_W-1:0] == cpu_req_addr[O_W-1:0]));

  p_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && in_win && !exp_req_valid) |->
      (cpu_req_ready && !conv_req_valid && cpu_rdata == {D_W{1'b1}}));

  p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
    !(conv_req_valid && exp_req_valid));

  p_ready_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (exp_req_valid |-> cpu_req_ready == exp_req_ready) and
    (conv_req_valid |-> cpu_req_ready == conv_req_ready));

  p_new_page_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(io_slot_wr) && cpu_req_valid && in_win &&
     cpu_req_addr[O_W+S_W-1:O_W] == $past(io_addr[S_W-1:0])) |->
      (exp_req_valid && exp_req_addr[EXP_W-1:O_W] == $past(io_wdata[P_W-1:0])));
endmodule

bind pager_window_map pmap_checker #(
  .A_W(A_W), .D_W(D_W), .O_W(O_W), .S_W(S_W), .P_W(P_W), .IOA_W(IOA_W),
  .WIN_BASE(WIN_BASE), .IO_BASE(IO_BASE)
) u_chk (
  .clk(clk), .rst(rst), .io_wr_en(io_wr_en), .io_addr(io_addr), .io_wdata(io_wdata),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_addr(cpu_req_addr), .cpu_rdata(cpu_rdata),
  .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
  .conv_req_addr(conv_req_addr), .exp_req_valid(exp_req_valid),
  .exp_req_ready(exp_req_ready), .exp_req_addr(exp_req_addr)
);

// File: tb/pager_window_map_bench.sv
module pager_window_map_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr_en = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [8:0]  io_wdata = '0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [19:0] cpu_req_addr = '0;
  logic [7:0]  cpu_req_wdata = '0;
  logic        cpu_req_ready;
  logic [7:0]  cpu_rdata;
  logic        conv_req_valid, conv_req_we;
  logic        conv_req_ready = 1'b1;
  logic [19:0] conv_req_addr;
  logic [7:0]  conv_req_wdata;
  logic [7:0]  conv_rdata = '0;
  logic        exp_req_valid, exp_req_we;
  logic        exp_req_ready = 1'b1;
  logic [21:0] exp_req_addr;
  logic [7:0]  exp_req_wdata;
  logic [7:0]  exp_rdata = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference state
  int pg [4];
  bit en [4];
  bit written [4];

  always #5 clk = ~clk;

  pager_window_map u_pager_window_map (
    .clk(clk), .rst(rst), .io_wr_en(io_wr_en), .io_addr(io_addr), .io_wdata(io_wdata),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_rdata(cpu_rdata),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_req_we(conv_req_we), .conv_req_addr(conv_req_addr),
    .conv_req_wdata(conv_req_wdata), .conv_rdata(conv_rdata),
    .exp_req_valid(exp_req_valid), .exp_req_ready(exp_req_ready),
    .exp_req_we(exp_req_we), .exp_req_addr(exp_req_addr),
    .exp_req_wdata(exp_req_wdata), .exp_rdata(exp_rdata)
  );

  task automatic compare(input string tag_in);
    string tag;
    bit hit;
    int k;
    bit e_cv, e_ev, e_rdy;
    logic [7:0]  e_rd;
    logic [21:0] e_ea;
    bit bad;
    hit = (cpu_req_addr >= 20'hE0000) && (cpu_req_addr < 20'hF0000);
    k = int'(cpu_req_addr[15:14]);
    e_ea = {pg[k][7:0], cpu_req_addr[13:0]};
    if (!hit) begin
      tag = "R3"; e_cv = cpu_req_valid; e_ev = 0; e_rdy = conv_req_ready; e_rd = conv_rdata;
    end else if (en[k]) begin
      tag = "R4"; e_cv = 0; e_ev = cpu_req_valid; e_rdy = exp_req_ready; e_rd = exp_rdata;
    end else begin
      tag = written[k] ? "R6" : "R1"; e_cv = 0; e_ev = 0; e_rdy = 1; e_rd = 8'hFF;
    end
    if (tag_in != "") tag = tag_in;
    bad = (conv_req_valid !== e_cv) || (exp_req_valid !== e_ev) ||
          (cpu_req_ready !== e_rdy) || (cpu_rdata !== e_rd);
    if (e_cv && (conv_req_addr !== cpu_req_addr || conv_req_we !== cpu_req_we ||
                 conv_req_wdata !== cpu_req_wdata)) bad = 1;
    if (e_ev && (exp_req_addr !== e_ea || exp_req_we !== cpu_req_we ||
                 exp_req_wdata !== cpu_req_wdata)) bad = 1;
    tests++;
    if (bad) begin
      fails++;
      $display("FAIL %s addr=%h: actual cv=%b ev=%b rdy=%b rd=%h ea=%h ca=%h expected cv=%b ev=%b rdy=%b rd=%h ea=%h",
               tag, cpu_req_addr, conv_req_valid, exp_req_valid, cpu_req_ready, cpu_rdata,
               exp_req_addr, conv_req_addr, e_cv, e_ev, e_rdy, e_rd, e_ea);
    end
  endtask

  // Drive at a falling edge, compare 1 ns later, update the model at the rising edge.
  task automatic step(input bit v, input bit we, input logic [19:0] a, input logic [7:0] wd,
                      input bit crdy, input bit erdy, input bit iow, input logic [7:0] ioa,
                      input logic [8:0] iod, input string tag);
    cpu_req_valid = v; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    conv_req_ready = crdy; exp_req_ready = erdy;
    conv_rdata = 8'($urandom); exp_rdata = 8'($urandom);
    io_wr_en = iow; io_addr = ioa; io_wdata = iod;
    #1 compare(tag);
    @(posedge clk);
    if (iow && ioa[7:2] == 6'h1A) begin
      pg[ioa[1:0]] = int'(iod[7:0]); en[ioa[1:0]] = iod[8]; written[ioa[1:0]] = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle_io_write(input logic [7:0] ioa, input logic [8:0] iod, input string tag);
    step(1, 0, 20'h00100, 8'h00, 1, 1, 1, ioa, iod, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin pg[i] = 0; en[i] = 0; written[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, every slot unmapped
    step(1, 0, 20'hE0000, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R1");
    step(1, 1, 20'hEC123, 8'h5A, 1, 1, 0, 8'h0, 9'h0, "R1");
    // R3: pass-through and window edges
    step(1, 1, 20'h12345, 8'hC3, 1, 1, 0, 8'h0, 9'h0, "R3");
    step(1, 0, 20'hDFFFF, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R3");
    step(1, 0, 20'hF0000, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R3");
    // R2: program slots 0 and 2, poke ports just outside the range
    idle_io_write(8'h68, 9'h105, "R2");
    idle_io_write(8'h6A, 9'h1A3, "R2");
    idle_io_write(8'h6C, 9'h177, "R2");
    idle_io_write(8'h67, 9'h199, "R2");
    step(1, 0, 20'hE0010, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R4");
    step(1, 1, 20'hEBFFF, 8'h11, 1, 1, 0, 8'h0, 9'h0, "R5");
    step(1, 0, 20'hE4000, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R2");
    step(1, 0, 20'hEFFFF, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R2");
    // R8: rewrite slot 0 while accessing it
    step(1, 0, 20'hE0200, 8'h00, 1, 1, 1, 8'h68, 9'h140, "R8");
    step(1, 0, 20'hE0200, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R8");
    // R6: disable slot 2, write through it is dropped
    step(1, 1, 20'hE8001, 8'h22, 1, 1, 1, 8'h6A, 9'h0A3, "R8");
    step(1, 1, 20'hE8001, 8'h22, 1, 1, 0, 8'h0, 9'h0, "R6");
    step(1, 0, 20'hE8001, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R6");
    // R7: back-pressure from each target
    step(1, 0, 20'hE0300, 8'h00, 1, 0, 0, 8'h0, 9'h0, "R7");
    step(1, 0, 20'hE0300, 8'h00, 0, 1, 0, 8'h0, 9'h0, "R7");
    step(1, 1, 20'h0ABCD, 8'h33, 0, 1, 0, 8'h0, 9'h0, "R7");
    step(1, 1, 20'h0ABCD, 8'h33, 0, 0, 0, 8'h0, 9'h0, "R7");
    step(0, 0, 20'hE0300, 8'h00, 1, 1, 0, 8'h0, 9'h0, "R7");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] a;
      logic [7:0] ioa;
      a = ($urandom_range(0, 1) == 1) ? {4'hE, 16'($urandom)} : 20'($urandom);
      ioa = 8'h66 + 8'($urandom_range(0, 7));
      step(bit'($urandom_range(0, 3) != 0), bit'($urandom), a, 8'($urandom),
           bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 3) != 0),
           bit'($urandom_range(0, 3) == 0), ioa, 9'($urandom), "");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule